// File: doc/BRIEF.md
# Ramp-Compare Conversion Capture Timer

This block is the digital half of a four-channel converter that works by timing a voltage ramp. A PWM synchronisation pulse restarts a 12-bit time counter. When the pulse ends, an external ramp starts to rise, and the counter measures how long the ramp takes to cross each analog input. Each channel's comparator output enters the block asynchronously. The first synchronised rising edge of that output after the pulse stores the running count in the channel's working (master) register.

At every rising edge of the sync pulse, all four working values move at once into readable holding (shadow) registers. A reader therefore always sees the conversion from the period that has just ended. A channel whose comparator never rose in a period is above the ramp peak. That channel reports an overvoltage code in place of a count. A software-side reader picks a channel with an index and gets a 16-bit, left-justified word. A valid flag tells the reader when the words hold real conversions.

Top module: `ramp_adc_capture`

## Requirements
- R1: While `pwm_sync` is high the time counter is zero. It starts advancing at the first clock edge at which `pwm_sync` is sampled low. At full rate, a comparator first sampled high at the edge that follows ramp cycle t (t = 0 is the first cycle with `pwm_sync` low) produces count t+2.
- R2: With `rate_fast` = 0 the counter advances on every second clock edge, the first advance coming at the second edge after the pulse ends. The same comparator timing as in R1 then yields count floor((t+2)/2). With `rate_fast` = 1 it advances on every edge.
- R3: The counter saturates at 4095 and never wraps.
- R4: Each channel captures only the first synchronised low-to-high comparator transition after the pulse ends. Later toggles in the same period leave its result unchanged.
- R5: Comparator inputs pass through a two-stage synchroniser and an edge detector. A capture therefore takes the count two clock edges after the input is first sampled high.
- R6: On a rising edge of `pwm_sync`, all four holding registers load at once. They stay unchanged at every other time.
- R7: A channel with no capture during the period reports 16'hFFF0.
- R8: A captured count c is reported as c shifted left by four bits, so bits 3:0 are always zero.
- R9: `data_valid` is low after reset and rises together with the second sync rising edge. It then stays high until reset.
- R10: `rd_sel` picks the channel on `rd_data` combinationally. Indices 0 to 2 are the main inputs and 3 is the auxiliary input.
- R11: After reset, `rd_data` reads 0 on every channel and `data_valid` is 0.
- R12: A comparator edge detected while `pwm_sync` is high, including the cycle in which the pulse rises, is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_fast | input | 1 | 1: count every clock; 0: count every second clock |
| pwm_sync | input | 1 | PWM synchronisation pulse (synchronous to clk) |
| cmp_in | input | 4 | Comparator outputs, asynchronous, bit 3 is auxiliary |
| rd_sel | input | 2 | Channel index for the read port |
| rd_data | output | 16 | Holding register of the selected channel |
| data_valid | output | 1 | Holding registers carry real conversions |

## Verification
A comparator edge can reach the capture logic in the same cycle that `pwm_sync` rises. In that cycle the holding registers load, the capture flags clear and the counter resets, all on one edge. The bench provokes this by raising one comparator two cycles before the pulse. That places the synchronised edge on the rise cycle. The reference model then expects that channel to read the overvoltage code, with no stray capture into the following period. Saturation is also made to coincide with a capture, and the bench checks that the count reads 4095 and has not wrapped.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  localparam int CNT_W  = 12;
  localparam int OUT_W  = 16;
  localparam int PAD_W  = OUT_W - CNT_W;
  localparam logic [OUT_W-1:0] OVR_CODE = 16'hFFF0;

  typedef logic [CNT_W-1:0] count_t;
  typedef logic [OUT_W-1:0] word_t;

  // saturating increment: all-ones is sticky
  function automatic count_t sat_step(input count_t v);
    if (&v) return v;
    return v + count_t'(1);
  endfunction

  // output word: left-justified count, or overvoltage code when no hit
  function automatic word_t out_code(input logic hit, input count_t v);
    if (hit) return {v, {PAD_W{1'b0}}};
    return OVR_CODE;
  endfunction

endpackage

// File: rtl/adc_ramp_counter.sv
module adc_ramp_counter
  import ramp_adc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  input  logic   rate_fast,
  output count_t count,
  output logic   tick
);

  logic phase;

  // half rate advances on the odd phase only
  assign tick = !hold && (rate_fast || phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      phase <= 1'b0;
    end else if (hold) begin
      count <= '0;
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
      if (tick) count <= sat_step(count);
    end
  end

endmodule

// File: rtl/adc_cmp_sync.sv
module adc_cmp_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise
);

  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[DEPTH-2:0], async_in[g]};
    end
    assign rise[g] = sh[STAGES-1] & ~sh[STAGES];
  end

endmodule

// File: rtl/adc_capture_pair.sv
module adc_capture_pair
  import ramp_adc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  input  logic   load,
  input  logic   edge_in,
  input  count_t count,
  output logic   captured,
  output word_t  shadow
);

  count_t master;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master   <= '0;
      captured <= 1'b0;
    end else if (hold) begin
      captured <= 1'b0;
    end else if (edge_in && !captured) begin
      master   <= count;
      captured <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    shadow <= '0;
    else if (load) shadow <= out_code(captured, master);
  end

endmodule

// File: rtl/ramp_adc_capture.sv
module ramp_adc_capture
  import ramp_adc_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_fast,
  input  logic             pwm_sync,
  input  logic [NCH-1:0]   cmp_in,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [OUT_W-1:0] rd_data,
  output logic             data_valid
);

  // named internal events, observed by the bound checker
  count_t         cnt_val;
  logic           tick_w;
  logic           sync_q;
  logic           sync_rise_w;
  logic [NCH-1:0] edge_w;
  logic [NCH-1:0] captured_w;
  logic           seen_rise;
  word_t          shadow_arr [NCH];

  assign sync_rise_w = pwm_sync & ~sync_q;

  adc_ramp_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (pwm_sync),
    .rate_fast (rate_fast),
    .count     (cnt_val),
    .tick      (tick_w)
  );

  adc_cmp_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .rise     (edge_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_pair
    adc_capture_pair u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (pwm_sync),
      .load     (sync_rise_w),
      .edge_in  (edge_w[g]),
      .count    (cnt_val),
      .captured (captured_w[g]),
      .shadow   (shadow_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= 1'b0;
      seen_rise  <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      sync_q <= pwm_sync;
      if (sync_rise_w) begin
        seen_rise <= 1'b1;
        if (seen_rise) data_valid <= 1'b1;
      end
    end
  end

  assign rd_data = shadow_arr[rd_sel];

endmodule

// File: rtl/adc_capture_checker.sv
module adc_capture_checker
  import ramp_adc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_fast,
  input logic             pwm_sync,
  input logic [SEL_W-1:0] rd_sel,
  input logic [OUT_W-1:0] rd_data,
  input logic             data_valid,
  input count_t           cnt_val,
  input logic             sync_rise_w,
  input logic [NCH-1:0]   edge_w,
  input logic [NCH-1:0]   captured_w
);

  a_r1_zero_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_sync |=> (cnt_val == '0));

  a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_sync && !rate_fast && $past(!pwm_sync) && $past(!rate_fast) && !$stable(cnt_val))
      |=> $stable(cnt_val));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_val) && !pwm_sync) |=> (&cnt_val));

  a_r6_load_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_rise_w |=> ($stable(rd_data) || !$stable(rd_sel)));

  a_r8_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:0] == 4'h0);

  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> data_valid);

  a_r9_valid_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(sync_rise_w));

  a_r12_clear_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_sync |=> (captured_w == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r4_capture_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(captured_w[g]) |-> $past(edge_w[g]));
  end

endmodule

bind ramp_adc_capture adc_capture_checker #(.NCH(NCH), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rate_fast   (rate_fast),
  .pwm_sync    (pwm_sync),
  .rd_sel      (rd_sel),
  .rd_data     (rd_data),
  .data_valid  (data_valid),
  .cnt_val     (cnt_val),
  .sync_rise_w (sync_rise_w),
  .edge_w      (edge_w),
  .captured_w  (captured_w)
);

// File: tb/ramp_adc_capture_test.sv
module ramp_adc_capture_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rate_fast;
  logic        pwm_sync;
  logic [3:0]  cmp_in;
  logic [1:0]  rd_sel;
  logic [15:0] rd_data;
  logic        data_valid;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;
  string cur_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_adc_capture uut (
    .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .pwm_sync(pwm_sync),
    .cmp_in(cmp_in), .rd_sel(rd_sel), .rd_data(rd_data), .data_valid(data_valid)
  );

  // behavioural reference model
  int m_cnt, m_ph, m_prev, m_seen, m_valid;
  int m_s1[4], m_s2[4], m_s3[4], m_cap[4], m_mst[4], m_shd[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_prev = 0; m_seen = 0; m_valid = 0;
      for (int c = 0; c < 4; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0; m_cap[c] = 0; m_mst[c] = 0; m_shd[c] = 0;
      end
    end else begin
      if (pwm_sync && !m_prev) begin
        for (int c = 0; c < 4; c++) m_shd[c] = m_cap[c] ? m_mst[c] * 16 : 'hFFF0;
        if (m_seen) m_valid = 1;
        m_seen = 1;
      end
      for (int c = 0; c < 4; c++) begin
        if (pwm_sync) m_cap[c] = 0;
        else if (m_s2[c] && !m_s3[c] && !m_cap[c]) begin
          m_mst[c] = m_cnt; m_cap[c] = 1;
        end
        m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = int'(cmp_in[c]);
      end
      if (pwm_sync) begin
        m_cnt = 0; m_ph = 0;
      end else begin
        if (rate_fast || m_ph) m_cnt = (m_cnt < 4095) ? m_cnt + 1 : 4095;
        m_ph = !m_ph;
      end
      m_prev = int'(pwm_sync);
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: compare model against outputs away from the edge
  task automatic step();
    @(negedge clk);
    #1;
    if (rst_n) begin
      check(cur_tag, int'(rd_data), m_shd[rd_sel], "rd_data vs model");
      check("R9", int'(data_valid), m_valid, "data_valid vs model");
    end
  endtask

  function automatic int closed_form(input bit fast, input int t, input int len);
    int c;
    if (t < 0 || t > len - 3) return 'hFFF0;
    c = fast ? t + 2 : (t + 2) / 2;
    if (c > 4095) c = 4095;
    return c * 16;
  endfunction

  // ramp phase of len cycles, then a four-cycle sync pulse with direct reads
  task automatic run_period(input string tag, input bit fast, input int len,
                            input int t0, input int t1, input int t2, input int t3,
                            input bit glitch);
    int t[4];
    t[0] = t0; t[1] = t1; t[2] = t2; t[3] = t3;
    cur_tag = tag;
    rate_fast = fast;
    for (int i = 0; i < len; i++) begin
      step();
      if (i == 0) pwm_sync = 1'b0;
      rd_sel = 2'(i % 4);
      for (int c = 0; c < 4; c++) begin
        if (t[c] == i) cmp_in[c] = 1'b1;
        if (glitch && t[c] >= 0 && i == t[c] + 4) cmp_in[c] = 1'b0;
        if (glitch && t[c] >= 0 && i == t[c] + 8) cmp_in[c] = 1'b1;
      end
    end
    step();
    pwm_sync = 1'b1;
    cmp_in   = '0;
    for (int j = 0; j < 4; j++) begin
      step();
      rd_sel = 2'(j);
      #1;
      check(tag, int'(rd_data), closed_form(fast, t[j], len), $sformatf("closed form ch%0d", j));
    end
  endtask

  initial begin
    rst_n = 1'b0; rate_fast = 1'b1; pwm_sync = 1'b0; cmp_in = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state on every channel
    for (int j = 0; j < 4; j++) begin
      step();
      rd_sel = 2'(j);
      #1;
      check("R11", int'(rd_data), 0, $sformatf("reset ch%0d", j));
      check("R11", int'(data_valid), 0, "reset valid");
    end
    // first sync pulse: contents not yet meaningful, valid stays low (R9)
    step();
    pwm_sync = 1'b1;
    repeat (4) step();
    check("R9", int'(data_valid), 0, "valid after first rise");
    // R1 R5 R8 R10: full rate, distinct crossing times, aux never crosses (R7)
    run_period("R1", 1'b1, 60, 3, 10, 20, -1, 1'b0);
    check("R9", int'(data_valid), 1, "valid after second rise");
    // R2: half rate
    run_period("R2", 1'b0, 80, 10, 25, 41, 7, 1'b0);
    // R4: comparator toggles after the first crossing are ignored
    run_period("R4", 1'b1, 100, 5, 30, 55, 12, 1'b1);
    // R3: saturation coincides with a capture
    run_period("R3", 1'b1, 4200, 4150, 5, 4000, -1, 1'b0);
    // R12: ch2 edge lands on the sync rise cycle; R7 for ch3
    run_period("R12", 1'b0, 50, 8, 20, 48, -1, 1'b0);
    // R6: holding values stay put through a ramp with no crossings until the next rise
    cur_tag = "R6";
    step();
    pwm_sync = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step();
      rd_sel = 2'(i % 4);
    end
    rd_sel = 2'd1;
    #1;
    check("R6", int'(rd_data), closed_form(1'b0, 20, 50), "held between rises");
    step();
    pwm_sync = 1'b1;
    repeat (2) step();
    check("R7", int'(rd_data), 'hFFF0, "no crossing gives overvoltage");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule